// File: doc/BRIEF.md
# Character Bank Register File with Nibble Loading

This block maps the 8 KB pattern space seen by the picture processor onto a larger character memory in 1 KB pieces. It holds eight bank registers, one for each 1 KB slice. The processor loads each 8-bit bank number as two separate 4-bit writes, low half and high half, to distinct addresses. A write to one half leaves the other half of that register as it was.

On the picture side, bits 12:10 of the pattern address choose the slice. The block returns that slice's bank number next to the untouched 10-bit offset within the bank. Register reads are combinational, so a value written on a clock edge is visible from that edge onward. Program banking and interrupt timing are handled elsewhere.

Top module: `chr_bank_map`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all eight bank registers read 0x00.
- R2: A low-half write replaces bits 3:0 of the addressed register with cpu_nib and keeps its bits 7:4.
- R3: A high-half write places cpu_nib into bits 7:4 of the addressed register and keeps its bits 3:0.
- R4: The register map is exact on the 16-bit address. Registers 0/1 are at 0xB000, 2/3 at 0xC000, 4/5 at 0xD000 and 6/7 at 0xE000. Within a group, offset 0x000 writes the even register's low half, 0x002 its high half, 0x004 the odd register's low half and 0x006 its high half.
- R5: Offsets 0x040, 0x080 and 0x0C0 in a group act the same as 0x002, 0x004 and 0x006.
- R6: A write to any other address, or any cycle with cpu_wr low, leaves every register unchanged.
- R7: bank_out equals the register selected by ppu_addr[12:10], where slice n covers 0x400*n to 0x400*n+0x3FF.
- R8: offset_out equals ppu_addr[9:0].
- R9: A value written at a clock edge appears on bank_out from that edge onward. Before the edge, bank_out still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Processor write strobe, one cycle per write |
| cpu_addr | input | 16 | Processor write address |
| cpu_nib | input | 4 | The 4 data bits that are loaded |
| ppu_addr | input | 13 | Pattern space address |
| bank_out | output | 8 | 1 KB bank number for the addressed slice |
| offset_out | output | 10 | Offset within the bank |

## Verification
The checker checks every cycle that at most one register is write-enabled and that idle cycles leave the register file stable. It also checks that bank_out and offset_out follow the register file and the pattern address, and that one sample address per write kind changes only its own half.

Only the bench scenarios show the full address map, the equivalence of the alternate offsets, and the rejection of near-miss addresses. The bench covers these by sweeping every register with every nibble value and reading back through all eight slices. It also shows the timing on both sides of the write edge.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  localparam int NIB_W  = 4;
  localparam int BANK_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    SEL_EVEN_LO = 2'd0,
    SEL_EVEN_HI = 2'd1,
    SEL_ODD_LO  = 2'd2,
    SEL_ODD_HI  = 2'd3
  } nib_sel_e;

  typedef struct packed {
    logic     valid;
    nib_sel_e sel;
  } low_dec_t;

  // Offset within a register group -> which half of which register
  function automatic low_dec_t decode_low(input logic [11:0] low);
    low_dec_t d;
    d.valid = 1'b1;
    d.sel   = SEL_EVEN_LO;
    case (low)
      12'h000:          d.sel = SEL_EVEN_LO;
      12'h002, 12'h040: d.sel = SEL_EVEN_HI;
      12'h004, 12'h080: d.sel = SEL_ODD_LO;
      12'h006, 12'h0C0: d.sel = SEL_ODD_HI;
      default:          d.valid = 1'b0;
    endcase
    return d;
  endfunction

  // Replace one half of a bank number, keep the other
  function automatic logic [BANK_W-1:0] merge_nib(input logic [BANK_W-1:0] old,
                                                  input logic [NIB_W-1:0]  nib,
                                                  input logic              hi);
    return hi ? {nib, old[NIB_W-1:0]} : {old[BANK_W-1:NIB_W], nib};
  endfunction
endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode
  import chr_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int GRP_FIRST = 'hB
) (
  input  logic                cpu_wr,
  input  logic [ADDR_W-1:0]   cpu_addr,
  output logic [NUM_REGS-1:0] wr_en,
  output logic                wr_hi
);
  localparam int NUM_GRP = NUM_REGS / 2;
  localparam int GRP_W   = ADDR_W - 12;

  low_dec_t           dec;
  logic [NUM_GRP-1:0] grp_hit;

  always_comb begin
    dec   = decode_low(cpu_addr[11:0]);
    wr_hi = dec.sel[0];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_hit[g] = (cpu_addr[ADDR_W-1:12] == GRP_W'(GRP_FIRST + g));
    for (genvar k = 0; k < 2; k++) begin : g_half
      assign wr_en[2*g+k] = cpu_wr && dec.valid && grp_hit[g] && (dec.sel[1] == k[0]);
    end
  end
endmodule

// File: rtl/chr_bank_file.sv
module chr_bank_file
  import chr_bank_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REGS-1:0]          wr_en,
  input  logic                         wr_hi,
  input  logic [NIB_W-1:0]             wr_nib,
  output logic [NUM_REGS*BANK_W-1:0]   bank_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BANK_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (wr_en[i]) q <= merge_nib(q, wr_nib, wr_hi);
    end
    assign bank_flat[i*BANK_W +: BANK_W] = q;
  end
endmodule

// File: rtl/chr_slice_sel.sv
module chr_slice_sel
  import chr_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SLICE_W  = 10
) (
  input  logic [NUM_REGS*BANK_W-1:0]         bank_flat,
  input  logic [SLICE_W+$clog2(NUM_REGS)-1:0] ppu_addr,
  output logic [BANK_W-1:0]                  bank_out,
  output logic [SLICE_W-1:0]                 offset_out
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [SEL_W-1:0] slice;

  always_comb begin
    slice      = ppu_addr[SLICE_W +: SEL_W];
    offset_out = ppu_addr[SLICE_W-1:0];
    bank_out   = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (slice == SEL_W'(i)) bank_out = bank_flat[i*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/chr_bank_map.sv
module chr_bank_map
  import chr_bank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int SLICE_W  = 10,
  parameter int PPU_W    = SLICE_W + $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [NIB_W-1:0]   cpu_nib,
  input  logic [PPU_W-1:0]   ppu_addr,
  output logic [BANK_W-1:0]  bank_out,
  output logic [SLICE_W-1:0] offset_out
);
  logic [NUM_REGS-1:0]        wr_en;
  logic                       wr_hi;
  logic [NUM_REGS*BANK_W-1:0] bank_flat;

  chr_wr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .wr_en(wr_en), .wr_hi(wr_hi)
  );

  chr_bank_file #(.NUM_REGS(NUM_REGS)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_nib(cpu_nib), .bank_flat(bank_flat)
  );

  chr_slice_sel #(.NUM_REGS(NUM_REGS), .SLICE_W(SLICE_W)) u_sel (
    .bank_flat(bank_flat), .ppu_addr(ppu_addr),
    .bank_out(bank_out), .offset_out(offset_out)
  );
endmodule

// File: rtl/chr_bank_chk.sv
module chr_bank_chk
  import chr_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SLICE_W  = 10
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              cpu_wr,
  input logic [15:0]                       cpu_addr,
  input logic [NIB_W-1:0]                  cpu_nib,
  input logic [SLICE_W+$clog2(NUM_REGS)-1:0] ppu_addr,
  input logic [BANK_W-1:0]                 bank_out,
  input logic [SLICE_W-1:0]                offset_out,
  input logic [NUM_REGS-1:0]               wr_en,
  input logic [NUM_REGS*BANK_W-1:0]        bank_flat
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic rst_seen_q;
  always_ff @(posedge clk) begin
    rst_seen_q <= !rst_n;
    if (rst_n && rst_seen_q)
      p_reset_clear_r1: assert (bank_flat == '0);
  end

  p_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'hB000) |=>
      (bank_flat[3:0] == $past(cpu_nib) && bank_flat[7:4] == $past(bank_flat[7:4])));

  p_high_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'hE006) |=>
      (bank_flat[63:60] == $past(cpu_nib) && bank_flat[59:56] == $past(bank_flat[59:56])));

  p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  p_alt_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'hC0C0) |=>
      (bank_flat[31:28] == $past(cpu_nib) && bank_flat[27:24] == $past(bank_flat[27:24])));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(bank_flat));

  p_slice_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_out == bank_flat[int'(ppu_addr[SLICE_W +: SEL_W])*BANK_W +: BANK_W]);

  p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    offset_out == ppu_addr[SLICE_W-1:0]);
endmodule

bind chr_bank_map chr_bank_chk #(.NUM_REGS(NUM_REGS), .SLICE_W(SLICE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_nib(cpu_nib), .ppu_addr(ppu_addr), .bank_out(bank_out),
  .offset_out(offset_out), .wr_en(wr_en), .bank_flat(bank_flat)
);

// File: tb/sim_chr_bank_map.sv
`timescale 1ns/1ps
module sim_chr_bank_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [3:0]  cpu_nib = '0;
  logic [12:0] ppu_addr = '0;
  logic [7:0]  bank_out;
  logic [9:0]  offset_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;

  chr_bank_map u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_nib(cpu_nib), .ppu_addr(ppu_addr), .bank_out(bank_out),
    .offset_out(offset_out)
  );

  function automatic logic [15:0] reg_addr(int r, bit hi, bit alt);
    int sel = (r % 2) * 2 + (hi ? 1 : 0);
    int base = 16'hB000 + (r / 2) * 16'h1000;
    return 16'(base + (alt ? sel * 16'h40 : sel * 2));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < 8; s++) begin
      logic [9:0] off = 10'((s * 97 + 5) % 1024);
      ppu_addr = {3'(s), off};
      #1;
      chk(req, {24'd0, bank_out}, {24'd0, model[s]});
      chk("R8", {22'd0, offset_out}, {22'd0, off});
    end
  endtask

  task automatic wr(logic [15:0] a, logic [3:0] n, bit strobe);
    @(negedge clk);
    cpu_wr = strobe; cpu_addr = a; cpu_nib = n;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    // R2 R3 R4 R5: every register, every nibble value, both address forms
    for (int r = 0; r < 8; r++) begin
      for (int v = 0; v < 16; v++) begin
        bit alt = v[0];
        wr(reg_addr(r, 0, alt), 4'(v), 1'b1);
        model[r][3:0] = 4'(v);
        sweep(alt ? "R2/R5" : "R2/R4");
        wr(reg_addr(r, 1, alt), 4'(15 - v), 1'b1);
        model[r][7:4] = 4'(15 - v);
        sweep(alt ? "R3/R5" : "R3/R4");
      end
      wr(reg_addr(r, 0, 0), 4'(r + 1), 1'b1);
      model[r][3:0] = 4'(r + 1);
      wr(reg_addr(r, 1, 1), 4'(8 - r), 1'b1);
      model[r][7:4] = 4'(8 - r);
    end
    sweep("R4");

    // R6: near-miss addresses and idle strobe
    begin
      logic [15:0] bad [10] = '{16'hB001, 16'hB003, 16'hB008, 16'hA000, 16'hF000,
                                16'hB100, 16'h7000, 16'hB042, 16'hC010, 16'h3006};
      for (int i = 0; i < 10; i++) begin
        wr(bad[i], 4'hF, 1'b1);
        sweep("R6");
      end
      wr(16'hB000, 4'hA, 1'b0);
      sweep("R6");
    end

    // R9: old value before the edge, new value after
    @(negedge clk);
    ppu_addr = {3'd5, 10'h3FF};
    cpu_wr = 1'b1; cpu_addr = 16'hD004; cpu_nib = 4'hC;
    #5;
    chk("R9", {24'd0, bank_out}, {24'd0, model[5]});
    model[5][3:0] = 4'hC;
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    chk("R9", {24'd0, bank_out}, {24'd0, model[5]});
    sweep("R9");

    // R1 again: reset clears after values were loaded
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    sweep("R1");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule